// File: doc/BRIEF.md
# Broadcast Payload Assembler and Bit Interleaver

This block forms the 32-bit payload word of a downlink broadcast channel and reorders its bits before the word goes on to scrambling and channel coding. A 24-bit message from higher layers occupies the low part of the word. Eight timing bits fill the upper part. They come from the low four bits of the frame counter, the half-frame flag, and either the upper block-index bits or the subcarrier-offset MSB. The choice between those last two depends on how many blocks the burst set may hold.

A one-cycle `start` pulse captures every input into one register. `done` pulses in the following cycle. The interleaved word is presented at that point and stays unchanged until the next `start`. The permutation is pure wiring from the captured register, so it adds no logic depth. The caller may issue `start` in consecutive cycles, and each result then appears one cycle after its own request.

Top module: `bcast_payload_top`

## Requirements
- R1: While reset is asserted (`rstN` low), `done` is 0 and `payloadOut` is all zeros.
- R2: `done` is 1 in exactly the cycle after each cycle in which `start` is 1, and it is 0 in every other cycle.
- R3: `payloadOut` keeps its value in every cycle that follows a cycle without `start`.
- R4: The permutation table, indexed 0 to 31, holds 16,23,18,17,8,30,10,6,24,7,0,5,3,2,1,4,9,11,12,13,14,15,19,20,21,22,25,26,27,28,29,31. Message bit i for i from 0 to 17 lands on output bit table[14+i]. Message bits 18 to 23 land on the output bits given by table entries 4 to 9, in that order, which are 8,30,10,6,24,7.
- R5: Frame-number bits 0 to 3 land on output bits 16,23,18,17, in that order (table entries 0 to 3). Frame-number bits 4 to 9 have no effect on the output.
- R6: The half-frame flag lands on output bit 0 (table entry 10).
- R7: When `maxBlocks` is 2 (a 64-block set), block-index bits 3, 4 and 5 land on output bits 5, 3 and 2 (table entries 11 to 13).
- R8: For any other `maxBlocks` code (0 = 4 blocks, 1 = 8 blocks, 3 = treated the same way), the subcarrier-offset MSB lands on output bit 5 and output bits 3 and 2 are 0. In this case the block index has no effect on the output.
- R9: Each `start` replaces the whole result. A result holds no bit from any earlier payload.
- R10: When `start` is high in consecutive cycles, each request's result appears one cycle after that request, in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture the inputs and build a new payload |
| msgIn | input | 24 | Higher-layer message bits |
| frameNum | input | 10 | Frame number (low four bits used) |
| halfFrame | input | 1 | Half-frame indicator |
| blockIdx | input | 6 | Block index within the burst set |
| maxBlocks | input | 2 | Burst-set size code: 0 = 4, 1 = 8, 2 = 64, 3 = treated as not 64 |
| scsMsb | input | 1 | MSB of the subcarrier offset |
| done | output | 1 | Result valid, one cycle after start |
| payloadOut | output | 32 | Interleaved payload, held until the next start |

## Verification
Capturing a new request and presenting the previous result can happen in the same cycle. This occurs when `start` is asserted while `done` is already high. The bench provokes it with bursts of `start` in consecutive cycles, and each burst carries payloads in different modes, so that every bit class changes from one request to the next. A scoreboard records one expected word per request and compares the words in order. A result that carries bits of its neighbour, or that appears one cycle early or late, then shows up as a mismatch or as an unexpected `done`.

// File: rtl/bcast_payload_pkg.sv
package bcast_payload_pkg;

  localparam int MSG_W   = 24;
  localparam int EXTRA_W = 8;
  localparam int PAY_W   = MSG_W + EXTRA_W;
  localparam int FRAME_W = 10;
  localparam int BLK_W   = 6;
  localparam int SFN_LSB = 4;
  localparam int MSG_LO_CNT = 18;  // message bits fed from table entries 14..31

  typedef enum logic [1:0] {
    SET_L4   = 2'd0,
    SET_L8   = 2'd1,
    SET_L64  = 2'd2,
    SET_RSVD = 2'd3
  } setSize_e;

  typedef struct packed {
    logic load;
  } ctrlStrobe_t;

  function automatic int permEntry(input int idx);
    case (idx)
      0: return 16;  1: return 23;  2: return 18;  3: return 17;
      4: return 8;   5: return 30;  6: return 10;  7: return 6;
      8: return 24;  9: return 7;   10: return 0;  11: return 5;
      12: return 3;  13: return 2;  14: return 1;  15: return 4;
      16: return 9;  17: return 11; 18: return 12; 19: return 13;
      20: return 14; 21: return 15; 22: return 19; 23: return 20;
      24: return 21; 25: return 22; 26: return 25; 27: return 26;
      28: return 27; 29: return 28; 30: return 29; default: return 31;
    endcase
  endfunction

  // Destination bit for each bit of the assembled word, selected by class.
  function automatic int destOf(input int srcBit);
    if (srcBit >= MSG_W && srcBit < MSG_W + SFN_LSB)
      return permEntry(srcBit - MSG_W);            // frame-number bits
    else if (srcBit == MSG_W + SFN_LSB)
      return permEntry(10);                        // half-frame bit
    else if (srcBit > MSG_W + SFN_LSB)
      return permEntry(11 + srcBit - (MSG_W + SFN_LSB + 1));
    else if (srcBit < MSG_LO_CNT)
      return permEntry(14 + srcBit);               // low message bits
    else
      return permEntry(4 + srcBit - MSG_LO_CNT);   // high message bits
  endfunction

endpackage

// File: rtl/bcast_payload_ctrl.sv
module bcast_payload_ctrl
  import bcast_payload_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output ctrlStrobe_t strobe,
  output logic        done
);

  always_comb strobe.load = start;

  always_ff @(posedge clk) begin
    if (!rstN) done <= 1'b0;
    else       done <= start;
  end

endmodule

// File: rtl/bcast_payload_dp.sv
module bcast_payload_dp
  import bcast_payload_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [MSG_W-1:0]   msgIn,
  input  logic [FRAME_W-1:0] frameNum,
  input  logic               halfFrame,
  input  logic [BLK_W-1:0]   blockIdx,
  input  logic [1:0]         maxBlocks,
  input  logic               scsMsb,
  output logic [PAY_W-1:0]   payloadOut
);

  logic [EXTRA_W-1:0] extraBits;
  logic [PAY_W-1:0]   payReg;
  logic               unusedInputs;

  assign unusedInputs = ^{frameNum[FRAME_W-1:SFN_LSB], blockIdx[2:0]};

  always_comb begin
    extraBits[SFN_LSB-1:0] = frameNum[SFN_LSB-1:0];
    extraBits[SFN_LSB]     = halfFrame;
    if (setSize_e'(maxBlocks) == SET_L64)
      extraBits[EXTRA_W-1:SFN_LSB+1] = blockIdx[BLK_W-1:3];
    else
      extraBits[EXTRA_W-1:SFN_LSB+1] = {2'b00, scsMsb};
  end

  // Whole-word load: a new request overwrites every bit.
  always_ff @(posedge clk) begin
    if (!rstN)            payReg <= '0;
    else if (strobe.load) payReg <= {extraBits, msgIn};
  end

  for (genvar g = 0; g < PAY_W; g++) begin : g_perm
    localparam int DEST = destOf(g);
    assign payloadOut[DEST] = payReg[g];
  end

endmodule

// File: rtl/bcast_payload_top.sv
module bcast_payload_top
  import bcast_payload_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [MSG_W-1:0]   msgIn,
  input  logic [FRAME_W-1:0] frameNum,
  input  logic               halfFrame,
  input  logic [BLK_W-1:0]   blockIdx,
  input  logic [1:0]         maxBlocks,
  input  logic               scsMsb,
  output logic               done,
  output logic [PAY_W-1:0]   payloadOut
);

  ctrlStrobe_t strobe;

  bcast_payload_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .done   (done)
  );

  bcast_payload_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .msgIn      (msgIn),
    .frameNum   (frameNum),
    .halfFrame  (halfFrame),
    .blockIdx   (blockIdx),
    .maxBlocks  (maxBlocks),
    .scsMsb     (scsMsb),
    .payloadOut (payloadOut)
  );

endmodule

// File: rtl/bcast_payload_checker.sv
module bcast_payload_checker (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        halfFrame,
  input logic [1:0]  maxBlocks,
  input logic        done,
  input logic [31:0] payloadOut
);

  p_done_follows_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done);

  p_done_needs_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !done);

  p_hold_without_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> $stable(payloadOut));

  p_half_frame_pos_r6: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (payloadOut[0] == $past(halfFrame)));

  p_small_set_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (start && maxBlocks != 2'd2) |=> (payloadOut[3:2] == 2'b00));

endmodule

bind bcast_payload_top bcast_payload_checker u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .halfFrame  (halfFrame),
  .maxBlocks  (maxBlocks),
  .done       (done),
  .payloadOut (payloadOut)
);

// File: tb/bcast_payload_top_bench.sv
module bcast_payload_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 5000;
  localparam int TBL [32] = '{16,23,18,17,8,30,10,6,24,7,0,5,3,2,1,4,
                              9,11,12,13,14,15,19,20,21,22,25,26,27,28,29,31};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [23:0] msgIn = '0;
  logic [9:0]  frameNum = '0;
  logic        halfFrame = 1'b0;
  logic [5:0]  blockIdx = '0;
  logic [1:0]  maxBlocks = '0;
  logic        scsMsb = 1'b0;
  logic        done;
  logic [31:0] payloadOut;

  int checks = 0;
  int errors = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic [31:0] lastExp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcast_payload_top u_bcast_payload_top (
    .clk(clk), .rstN(rstN), .start(start), .msgIn(msgIn), .frameNum(frameNum),
    .halfFrame(halfFrame), .blockIdx(blockIdx), .maxBlocks(maxBlocks),
    .scsMsb(scsMsb), .done(done), .payloadOut(payloadOut)
  );

  function automatic logic [31:0] refModel(input logic [23:0] m, input logic [9:0] f,
                                           input logic h, input logic [5:0] b,
                                           input logic [1:0] mode, input logic s);
    logic [31:0] res;
    res = '0;
    for (int i = 0; i < 18; i++) res[TBL[14+i]] = m[i];
    for (int i = 18; i < 24; i++) res[TBL[i-14]] = m[i];
    for (int i = 0; i < 4; i++) res[TBL[i]] = f[i];
    res[TBL[10]] = h;
    if (mode == 2'd2) begin
      res[TBL[11]] = b[3]; res[TBL[12]] = b[4]; res[TBL[13]] = b[5];
    end else begin
      res[TBL[11]] = s;
    end
    return res;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drives one request; leaves start high so back-to-back calls form a burst.
  task automatic issue(input string tag, input logic [23:0] m, input logic [9:0] f,
                       input logic h, input logic [5:0] b, input logic [1:0] mode,
                       input logic s);
    @(negedge clk);
    msgIn = m; frameNum = f; halfFrame = h; blockIdx = b; maxBlocks = mode; scsMsb = s;
    start = 1'b1;
    lastExp = refModel(m, f, h, b, mode, s);
    expQ.push_back(lastExp);
    tagQ.push_back(tag);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    start = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops expected words as results appear.
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: done high with no request, actual 1 expected 0");
      end else begin
        check(tagQ.pop_front(), payloadOut, expQ.pop_front());
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 payload", payloadOut, 32'h0);
    check("R1 done", {31'b0, done}, 32'h0);
    rstN = 1'b1;
    idle(1);

    issue("R4 mixed message", 24'hA5C3F1, 10'h0, 1'b0, 6'h0, 2'd0, 1'b0);
    idle(2);
    issue("R4 high message bits", 24'hFC0000, 10'h0, 1'b0, 6'h0, 2'd1, 1'b0);
    idle(2);
    issue("R5 frame bits upper ignored", 24'h0, 10'h3F5, 1'b0, 6'h0, 2'd0, 1'b0);
    idle(2);
    issue("R6 half frame", 24'h0, 10'h0, 1'b1, 6'h0, 2'd0, 1'b0);
    idle(2);
    issue("R7 block index 64-set", 24'h0, 10'h0, 1'b0, 6'b101000, 2'd2, 1'b0);
    idle(2);
    issue("R8 scs msb, index ignored", 24'h0, 10'h0, 1'b0, 6'h3F, 2'd1, 1'b1);
    idle(2);
    issue("R8 reserved code", 24'h0, 10'h0, 1'b0, 6'h3F, 2'd3, 1'b0);
    idle(2);
    issue("R9 all ones", 24'hFFFFFF, 10'h3FF, 1'b1, 6'h3F, 2'd2, 1'b1);
    idle(2);
    issue("R9 all zero after ones", 24'h0, 10'h0, 1'b0, 6'h0, 2'd0, 1'b0);
    idle(1);
    check("R3 hold zero", payloadOut, lastExp);
    check("R2 done low when idle", {31'b0, done}, 32'h0);

    issue("R10 burst first", 24'h123456, 10'h00A, 1'b1, 6'b011000, 2'd2, 1'b0);
    issue("R10 burst second", 24'hFEDCBA, 10'h005, 1'b0, 6'b111111, 2'd0, 1'b1);
    issue("R10 burst third", 24'h0F0F0F, 10'h3F3, 1'b1, 6'b100000, 2'd2, 1'b1);
    idle(1);
    repeat (4) @(negedge clk);
    check("R3 hold after burst", payloadOut, lastExp);
    check("R2 queue drained", 32'(expQ.size()), 32'h0);
    summary();
  end

endmodule